// File: doc/BRIEF.md
# Stereo Audio Sample Buffer with Status Interrupts

This block buffers 32-bit stereo audio words between a 32-bit register bus and a serial audio port. Playback words written by software or a DMA engine to a transmit data register enter a transmit FIFO. The serialiser drains that FIFO one word per request. Capture words pushed by the serialiser enter a receive FIFO, and a read of the receive data register drains it. Each FIFO is 32 entries deep.

A level register reports the free transmit space and the receive fill at any time. Eight sticky flags record four events in each direction: the fill has crossed a programmable threshold, a word was needed from an empty FIFO, a word arrived at a full FIFO, and the DMA engine reported a fault. Each flag is cleared by writing 1 to it. An enable mask selects which flags drive the interrupt output. Two level outputs ask the DMA engine to move words.

The global enable bit works as a soft reset. While it is 0, every control register, flag and FIFO is held at its reset value, and only the configuration register accepts writes.

Top module: `audio_fifo_xfer`

## Requirements
- R1: After reset, CFG (offset 0x00) reads 0x0000_4040, the flag register (0x04) and mask register (0x08) read 0, LEVEL (0x0C) reads 0x0000_0020, and irq, both DMA requests and ser_tx_word are 0.
- R2: Each FIFO holds 32 words in first-in first-out order. LEVEL bits 5:0 give the free transmit entries and bits 13:8 give the filled receive entries.
- R3: CFG fields are: bit 31 global enable, bit 30 DMA enable, bit 24 transmit enable, bit 20 receive enable, bits 15:12 receive threshold, bits 7:4 transmit threshold. The other bits read 0. A CFG write with bit 31 set stores these fields. A CFG write with bit 31 clear restores every register and empties both FIFOs.
- R4: A write to TXDATA (0x10) pushes a word. When transmit is enabled, a ser_tx_req pulse pops the head word into ser_tx_word on the next clock edge.
- R5: A ser_tx_req to an empty transmit FIFO sets flag bit 1 and loads ser_tx_word with 0.
- R6: A TXDATA write to a full transmit FIFO is dropped and sets flag bit 2. A ser_rx_push to a full receive FIFO is dropped and sets flag bit 6.
- R7: A read of RXDATA (0x14) returns the receive head word and pops it. A read of an empty receive FIFO returns 0 and sets flag bit 5.
- R8: Flag bit 0 is set while transmit is enabled and the transmit fill is below the transmit threshold. Flag bit 4 is set while receive is enabled and the receive fill is at or above the receive threshold.
- R9: A tx_dma_err pulse sets flag bit 3. An rx_dma_err pulse sets flag bit 7.
- R10: Writing 1 to a flag bit clears it. If the bit's set condition is present in the same cycle, the set wins.
- R11: irq is high exactly when some flag bit and its mask bit are both 1.
- R12: With enable, DMA enable and transmit enable set, dma_tx_req is high while the transmit FIFO is not full. With enable, DMA enable and receive enable set, dma_rx_req is high while the receive fill is nonzero and at or above the receive threshold.
- R13: While the global enable is 0, writes to the mask register and TXDATA, ser_tx_req and ser_rx_push have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_tx_req | input | 1 | Serialiser asks for the next playback word |
| ser_tx_word | output | 32 | Playback word handed to the serialiser |
| ser_rx_push | input | 1 | Serialiser delivers a capture word |
| ser_rx_word | input | 32 | Capture word |
| tx_dma_err | input | 1 | DMA fault on the playback side |
| rx_dma_err | input | 1 | DMA fault on the capture side |
| dma_tx_req | output | 1 | Request for the DMA engine to write playback words |
| dma_rx_req | output | 1 | Request for the DMA engine to read capture words |
| irq | output | 1 | Interrupt |

## Verification
A wrong FIFO pointer or count shows up in LEVEL on the next access, and as out-of-order or repeated words at ser_tx_word or RXDATA one pop later. A missed or stuck flag shows up in the flag register and on irq one cycle after the event. A soft reset that clears only part of the state leaves a nonzero LEVEL, mask or flag readback right after the disabling write. Long random runs of push, pop, read and receive traffic catch drift between the counts and the data path.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

  localparam int unsigned AW_BUS = 6;

  localparam logic [AW_BUS-1:0] OFF_CFG = 6'h00;
  localparam logic [AW_BUS-1:0] OFF_FLG = 6'h04;
  localparam logic [AW_BUS-1:0] OFF_MSK = 6'h08;
  localparam logic [AW_BUS-1:0] OFF_LVL = 6'h0C;
  localparam logic [AW_BUS-1:0] OFF_TXD = 6'h10;
  localparam logic [AW_BUS-1:0] OFF_RXD = 6'h14;

  localparam int unsigned THR_W     = 4;
  localparam logic [THR_W-1:0] THR_RST = 4'd4;
  localparam int unsigned NFLAG     = 8;
  localparam int unsigned RX_LVL_LSB = 8;

  // flag indices
  localparam int unsigned F_TX_THR = 0;
  localparam int unsigned F_TX_UDR = 1;
  localparam int unsigned F_TX_OVR = 2;
  localparam int unsigned F_TX_FLT = 3;
  localparam int unsigned F_RX_THR = 4;
  localparam int unsigned F_RX_UDR = 5;
  localparam int unsigned F_RX_OVR = 6;
  localparam int unsigned F_RX_FLT = 7;

  typedef struct packed {
    logic             en;
    logic             dma;
    logic             tx_en;
    logic             rx_en;
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
  } ctl_t;

  localparam ctl_t CTL_RST = '{en: 1'b0, dma: 1'b0, tx_en: 1'b0, rx_en: 1'b0,
                               rx_thr: THR_RST, tx_thr: THR_RST};

  function automatic ctl_t ctl_from_word(input logic [31:0] w);
    ctl_t c;
    c.en     = w[31];
    c.dma    = w[30];
    c.tx_en  = w[24];
    c.rx_en  = w[20];
    c.rx_thr = w[15:12];
    c.tx_thr = w[7:4];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c);
    return {c.en, c.dma, 5'b0, c.tx_en, 3'b0, c.rx_en, 4'b0,
            c.rx_thr, 4'b0, c.tx_thr, 4'b0};
  endfunction

endpackage

// File: rtl/afifo_ring.sv
module afifo_ring #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign rdata   = mem[rp_q];
  assign cnt     = cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = step(wp_q);
      if (do_pop)  rp_n = step(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/afifo_ctl.sv
module afifo_ctl
  import audio_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             msk_we,
  input  logic             flg_we,
  input  logic [31:0]      wdata,
  input  logic [NFLAG-1:0] flag_set,
  output ctl_t             ctl,
  output logic [NFLAG-1:0] msk,
  output logic [NFLAG-1:0] flg
);

  ctl_t             ctl_q, ctl_n;
  logic [NFLAG-1:0] msk_q, msk_n, flg_q, flg_n;

  always_comb begin
    ctl_n = ctl_q;
    if (cfg_we) ctl_n = wdata[31] ? ctl_from_word(wdata) : CTL_RST;

    if (!ctl_q.en) begin
      msk_n = '0;
      flg_n = '0;
    end else begin
      msk_n = msk_we ? wdata[NFLAG-1:0] : msk_q;
      flg_n = (flg_q & ~(flg_we ? wdata[NFLAG-1:0] : '0)) | flag_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      msk_q <= '0;
      flg_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      msk_q <= msk_n;
      flg_q <= flg_n;
    end
  end

  assign ctl = ctl_q;
  assign msk = msk_q;
  assign flg = flg_q;

endmodule

// File: rtl/audio_fifo_xfer.sv
module audio_fifo_xfer
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ser_tx_req,
  output logic [DW-1:0] ser_tx_word,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_word,
  input  logic          tx_dma_err,
  input  logic          rx_dma_err,
  output logic          dma_tx_req,
  output logic          dma_rx_req,
  output logic          irq
);

  ctl_t             ctl;
  logic [NFLAG-1:0] msk, flg, flag_set;
  logic             wr_cfg, wr_msk, wr_flg, wr_txd, rd_rxd;
  logic             en, tx_act, rx_act;
  logic [DW-1:0]    tx_head, rx_head;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_pop;
  logic [DW-1:0]    tx_word_q, tx_word_n;

  // bus decode
  assign wr_cfg = bus_sel & bus_wr & (bus_addr == OFF_CFG);
  assign wr_msk = bus_sel & bus_wr & (bus_addr == OFF_MSK);
  assign wr_flg = bus_sel & bus_wr & (bus_addr == OFF_FLG);
  assign wr_txd = bus_sel & bus_wr & (bus_addr == OFF_TXD);
  assign rd_rxd = bus_sel & ~bus_wr & (bus_addr == OFF_RXD);

  assign en     = ctl.en;
  assign tx_act = ctl.en & ctl.tx_en;
  assign rx_act = ctl.en & ctl.rx_en;
  assign tx_pop = tx_act & ser_tx_req;

  afifo_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (wr_cfg),
    .msk_we   (wr_msk),
    .flg_we   (wr_flg),
    .wdata    (bus_wdata),
    .flag_set (flag_set),
    .ctl      (ctl),
    .msk      (msk),
    .flg      (flg)
  );

  afifo_ring #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~en),
    .push  (wr_txd),
    .pop   (tx_pop),
    .wdata (bus_wdata[DW-1:0]),
    .rdata (tx_head),
    .cnt   (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  afifo_ring #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~en),
    .push  (rx_act & ser_rx_push),
    .pop   (rd_rxd),
    .wdata (ser_rx_word),
    .rdata (rx_head),
    .cnt   (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // event detection
  always_comb begin
    flag_set           = '0;
    flag_set[F_TX_THR] = tx_act & (tx_cnt < CW'(ctl.tx_thr));
    flag_set[F_TX_UDR] = tx_pop & tx_empty;
    flag_set[F_TX_OVR] = en & wr_txd & tx_full;
    flag_set[F_TX_FLT] = en & tx_dma_err;
    flag_set[F_RX_THR] = rx_act & (rx_cnt >= CW'(ctl.rx_thr));
    flag_set[F_RX_UDR] = en & rd_rxd & rx_empty;
    flag_set[F_RX_OVR] = rx_act & ser_rx_push & rx_full;
    flag_set[F_RX_FLT] = en & rx_dma_err;
  end

  // playback word register
  always_comb begin
    tx_word_n = tx_word_q;
    if (!en)         tx_word_n = '0;
    else if (tx_pop) tx_word_n = tx_empty ? '0 : tx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_word_q <= '0;
    else        tx_word_q <= tx_word_n;
  end

  assign ser_tx_word = tx_word_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CFG: bus_rdata = ctl_to_word(ctl);
      OFF_FLG: bus_rdata = 32'(flg);
      OFF_MSK: bus_rdata = 32'(msk);
      OFF_LVL: begin
        bus_rdata[CW-1:0]                   = CW'(DEPTH) - tx_cnt;
        bus_rdata[RX_LVL_LSB +: CW]         = rx_cnt;
      end
      OFF_RXD: bus_rdata = rx_empty ? '0 : 32'(rx_head);
      default: bus_rdata = '0;
    endcase
  end

  assign irq        = |(flg & msk);
  assign dma_tx_req = tx_act & ctl.dma & ~tx_full;
  assign dma_rx_req = rx_act & ctl.dma & ~rx_empty & (rx_cnt >= CW'(ctl.rx_thr));

endmodule

// File: rtl/audio_fifo_xfer_chk.sv
module audio_fifo_xfer_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tx_act,
  input logic          wr_txd,
  input logic          ser_tx_req,
  input logic [DW-1:0] ser_tx_word,
  input logic          tx_dma_err,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    flg,
  input logic [7:0]    msk,
  input logic          irq,
  input logic          dma_tx_req
);

  // R2: counts never exceed the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  // R5: empty pop gives zero and flags underrun
  a_r5_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && ser_tx_req && tx_cnt == '0) |=> (ser_tx_word == '0 && flg[1]));

  // R6: write to a full playback FIFO flags overrun and keeps it full
  a_r6_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_txd && tx_cnt == CW'(DEPTH) && !ser_tx_req) |=> (flg[2] && tx_cnt == CW'(DEPTH)));

  // R9: DMA fault reaches the flag register
  a_r9_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_dma_err) |=> flg[3]);

  // R11: no interrupt without an enabled flag
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg & msk) == '0) |-> !irq);

  // R12: no playback request while full
  a_r12_dma_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (tx_cnt != CW'(DEPTH)));

  // R13: disabled state empties everything
  a_r13_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (flg == '0 && msk == '0 && tx_cnt == '0 && rx_cnt == '0));

endmodule

bind audio_fifo_xfer audio_fifo_xfer_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .tx_act      (tx_act),
  .wr_txd      (wr_txd),
  .ser_tx_req  (ser_tx_req),
  .ser_tx_word (ser_tx_word),
  .tx_dma_err  (tx_dma_err),
  .tx_cnt      (tx_cnt),
  .rx_cnt      (rx_cnt),
  .flg         (flg),
  .msk         (msk),
  .irq         (irq),
  .dma_tx_req  (dma_tx_req)
);

// File: tb/audio_fifo_xfer_tb.sv
module audio_fifo_xfer_tb;

  localparam int DEPTH = 32;
  localparam logic [5:0] A_CFG = 6'h00, A_FLG = 6'h04, A_MSK = 6'h08,
                         A_LVL = 6'h0C, A_TXD = 6'h10, A_RXD = 6'h14;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ser_tx_req, ser_rx_push;
  logic [31:0] ser_tx_word, ser_rx_word;
  logic        tx_dma_err, rx_dma_err;
  logic        dma_tx_req, dma_rx_req, irq;

  int tests = 0;
  int fails = 0;

  audio_fifo_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx_req(ser_tx_req), .ser_tx_word(ser_tx_word),
    .ser_rx_push(ser_rx_push), .ser_rx_word(ser_rx_word),
    .tx_dma_err(tx_dma_err), .rx_dma_err(rx_dma_err),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] exp_lvl(input int txn, input int rxn);
    return 32'(DEPTH - txn) | (32'(rxn) << 8);
  endfunction

  function automatic logic [31:0] exp_cfg(input bit e, input bit d, input bit t,
                                          input bit r, input int rthr, input int tthr);
    return {e, d, 5'b0, t, 3'b0, r, 4'b0, 4'(rthr), 4'b0, 4'(tthr), 4'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); ser_tx_req = 1'b1;
    @(negedge clk); ser_tx_req = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk); ser_rx_push = 1'b1; ser_rx_word = d;
    @(negedge clk); ser_rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [7:0]  sticky;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    ser_tx_req = 0; ser_rx_push = 0; ser_rx_word = 0;
    tx_dma_err = 0; rx_dma_err = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(A_CFG, rd); check("R1 cfg", rd, 32'h0000_4040);
    reg_read(A_FLG, rd); check("R1 flags", rd, 0);
    reg_read(A_MSK, rd); check("R1 mask", rd, 0);
    reg_read(A_LVL, rd); check("R1 level", rd, exp_lvl(0, 0));
    check("R1 outputs", {irq, dma_tx_req, dma_rx_req}, 0);
    check("R1 tx word", ser_tx_word, 0);

    // R13 disabled: writes and serial events ignored
    reg_write(A_MSK, 32'hFF);
    reg_read(A_MSK, rd); check("R13 mask ignored", rd, 0);
    reg_write(A_TXD, 32'h1234_5678);
    push_rx(32'h5555_0000);
    reg_read(A_LVL, rd); check("R13 fifo ignored", rd, exp_lvl(0, 0));

    // R3 configuration
    reg_write(A_CFG, exp_cfg(1, 0, 1, 1, 2, 3));
    reg_read(A_CFG, rd); check("R3 cfg readback", rd, exp_cfg(1, 0, 1, 1, 2, 3));

    // R8 / R10 transmit threshold flag, set wins over clear
    reg_read(A_FLG, rd); check("R8 tx below thr", rd, 32'h01);
    reg_write(A_FLG, 32'h01);
    reg_read(A_FLG, rd); check("R10 set wins", rd, 32'h01);
    for (int i = 0; i < 3; i++) reg_write(A_TXD, 32'hA000_0000 + 32'(i));
    reg_write(A_FLG, 32'h01);
    reg_read(A_FLG, rd); check("R10 w1c clears", rd, 32'h00);

    // R8 receive threshold, R7 reads
    push_rx(32'hC000_0001);
    push_rx(32'hC000_0002);
    reg_read(A_LVL, rd); check("R2 level", rd, exp_lvl(3, 2));
    reg_read(A_FLG, rd); check("R8 rx at thr", rd, 32'h10);
    reg_read(A_RXD, rd); check("R7 rx word0", rd, 32'hC000_0001);
    reg_read(A_RXD, rd); check("R7 rx word1", rd, 32'hC000_0002);

    // R9 fault flags
    @(negedge clk); tx_dma_err = 1; @(negedge clk); tx_dma_err = 0;
    @(negedge clk); rx_dma_err = 1; @(negedge clk); rx_dma_err = 0;
    reg_read(A_FLG, rd); check("R9 faults", rd, 32'h98);
    reg_write(A_FLG, 32'hFF);
    reg_read(A_FLG, rd); check("R10 clear all", rd, 32'h00);

    // R11 interrupt
    reg_write(A_MSK, 32'h08);
    check("R11 irq idle", irq, 0);
    @(negedge clk); tx_dma_err = 1; @(negedge clk); tx_dma_err = 0;
    check("R11 irq raised", irq, 1);
    reg_write(A_FLG, 32'h08);
    check("R11 irq cleared", irq, 0);

    // R6 transmit overrun, R4 order, R5 underrun
    for (int i = 3; i < DEPTH; i++) reg_write(A_TXD, 32'hA000_0000 + 32'(i));
    reg_write(A_TXD, 32'hDEAD_BEEF);
    reg_read(A_LVL, rd); check("R6 tx full level", rd, exp_lvl(DEPTH, 0));
    reg_read(A_FLG, rd); check("R6 tx overrun", rd & 32'h04, 32'h04);
    for (int i = 0; i < DEPTH; i++) begin
      pulse_tx();
      check("R4 tx order", ser_tx_word, 32'hA000_0000 + 32'(i));
    end
    pulse_tx();
    check("R5 underrun word", ser_tx_word, 0);
    reg_read(A_FLG, rd); check("R5 underrun flag", rd & 32'h06, 32'h06);
    reg_write(A_FLG, 32'hFF);

    // R6 receive overrun, R7 empty read
    for (int i = 0; i <= DEPTH; i++) push_rx(32'hB000_0000 + 32'(i));
    reg_read(A_FLG, rd); check("R6 rx overrun", rd & 32'h40, 32'h40);
    for (int i = 0; i < DEPTH; i++) begin
      reg_read(A_RXD, rd); check("R7 rx order", rd, 32'hB000_0000 + 32'(i));
    end
    reg_read(A_RXD, rd); check("R7 empty read", rd, 0);
    reg_read(A_FLG, rd); check("R7 rx underrun", rd & 32'h20, 32'h20);

    // R12 DMA requests
    reg_write(A_CFG, exp_cfg(1, 1, 1, 1, 2, 3));
    check("R12 tx req", dma_tx_req, 1);
    check("R12 rx idle", dma_rx_req, 0);
    push_rx(32'h1);
    check("R12 rx below", dma_rx_req, 0);
    push_rx(32'h2);
    check("R12 rx at thr", dma_rx_req, 1);

    // R3 soft reset
    reg_write(A_MSK, 32'hFF);
    reg_write(A_CFG, 32'h7FFF_FFFF);
    reg_read(A_CFG, rd); check("R3 soft reset cfg", rd, 32'h0000_4040);
    reg_read(A_MSK, rd); check("R3 soft reset mask", rd, 0);
    reg_read(A_FLG, rd); check("R3 soft reset flags", rd, 0);
    reg_read(A_LVL, rd); check("R3 soft reset level", rd, exp_lvl(0, 0));
    check("R3 soft reset outs", {irq, dma_tx_req, dma_rx_req}, 0);

    // random traffic: R2 R4 R5 R6 R7
    reg_write(A_CFG, exp_cfg(1, 0, 1, 1, 0, 0));
    reg_write(A_FLG, 32'hFF);
    sticky = 0;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      int op;
      op = int'($urandom % 4);
      d = $urandom;
      case (op)
        0: begin
          if (txq.size() < DEPTH) txq.push_back(d); else sticky |= 8'h04;
          reg_write(A_TXD, d);
        end
        1: begin
          logic [31:0] e;
          if (txq.size() > 0) e = txq.pop_front();
          else begin e = 0; sticky |= 8'h02; end
          pulse_tx();
          check("R4 random tx word", ser_tx_word, e);
        end
        2: begin
          if (rxq.size() < DEPTH) rxq.push_back(d); else sticky |= 8'h40;
          push_rx(d);
        end
        default: begin
          logic [31:0] e;
          if (rxq.size() > 0) e = rxq.pop_front();
          else begin e = 0; sticky |= 8'h20; end
          reg_read(A_RXD, rd);
          check("R7 random rx word", rd, e);
        end
      endcase
      if (n % 8 == 0) begin
        reg_read(A_LVL, rd);
        check("R2 random level", rd, exp_lvl(txq.size(), rxq.size()));
      end
    end
    reg_read(A_FLG, rd); check("R6 random flags", rd & 32'h66, 32'(sticky));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule